// File: doc/BRIEF.md
# Status LED Pin Driver

This block drives two status LED pins for an Ethernet port. Each pin is given its own 4-bit selector, which chooses what the LED shows:

- a status level: link up, link down or full duplex;
- an activity event: transmit, receive, collision, or transmit-or-receive;
- a fixed state: forced on or forced off;
- a blink: slow or fast.

Short activity events are pulse-stretched so that a person can see them. The stretch length is counted in millisecond ticks and can be set to normal (40), medium (70) or long (140) ticks. A separate enable bypasses stretching and shows the raw event.

Each LED can be wired in one of two ways: to ground, so the pin sources current to light it, or to the supply, so the pin sinks current. The pin cannot know this in advance. After reset the block waits a short settle window and then samples a sense bit for each pin, which stands in for the analog detection. From then on it drives each pin with the polarity that makes the chosen state visible. The sense bit of the second LED also sets the default duplex bit given to the rest of the port. Until sampling is done, both pins stay undriven and low.

Top module: `led_beacon_top`

## Requirements
- R1: While `rstN` is low, and for `SENSE_CYCLES` (default 8) clocks after its release, `ledAOe`, `ledBOe`, `ledAOut` and `ledBOut` are 0. Both output enables rise together on the `SENSE_CYCLES+1`-th rising clock edge after the release.
- R2: A sense bit of 0 means the pin sources current to light the LED, so the pin is driven high when the LED is lit. A sense bit of 1 means the pin sinks current, so the pin is driven low when the LED is lit.
- R3: `duplexDefault` equals the sampled `senseB`: 1 (full duplex) when LED B sinks current, 0 (half duplex) when it sources current. It does not change while the pins are enabled.
- R4: Changes on `senseA` or `senseB` after sampling have no effect on pin drive or on `duplexDefault` until the next reset.
- R5: The selector codes are: 0 link up, 1 transmit, 2 receive, 3 collision, 4 full duplex, 5 transmit or receive, 6 link down, 8 forced on, 9 forced off, 10 fast blink, 11 slow blink. The codes 7 and 12 to 15 are off. The pin reflects the inputs one clock after they are sampled.
- R6: With `stretchEn` = 1, an activity event keeps the LED lit for L further `msTick` pulses after it drops. L is 40 when `stretchSel` = 0, 70 when it is 1, and 140 when it is 2 or 3.
- R7: A new event during a running stretch restarts the count from the full length L.
- R8: With `stretchEn` = 0, an activity event is shown only for the cycles in which it is high. The level sources are not affected by this enable.
- R9: Slow blink is lit for 100 ticks out of each period of 200 ticks. Fast blink is lit for 50 ticks out of each period of 100 ticks.
- R10: The stretch count advances only on cycles in which `msTick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msTick | input | 1 | One-cycle pulse per millisecond |
| linkUp | input | 1 | Link status level |
| txActive | input | 1 | Transmit activity event |
| rxActive | input | 1 | Receive activity event |
| collision | input | 1 | Collision event |
| fullDuplex | input | 1 | Current duplex status level |
| cfgA | input | 4 | Source and mode selector for LED A |
| cfgB | input | 4 | Source and mode selector for LED B |
| stretchEn | input | 1 | 1: stretch activity events; 0: show them raw |
| stretchSel | input | 2 | Stretch length choice |
| senseA | input | 1 | Sensed wiring of LED A (1 = sinks current) |
| senseB | input | 1 | Sensed wiring of LED B (1 = sinks current) |
| ledAOut | output | 1 | Drive value of LED A pin |
| ledAOe | output | 1 | Output enable of LED A pin |
| ledBOut | output | 1 | Drive value of LED B pin |
| ledBOe | output | 1 | Output enable of LED B pin |
| duplexDefault | output | 1 | Reset-time duplex default |

## Verification
The hardest case to reach from the ports is a stretch whose counter is frozen or restarted in mid-count. The stimulus reaches it by first idling the event long enough to clear any earlier stretch, then issuing one-cycle pulses at known cycle offsets, and holding `msTick` low for a known gap. The bench then compares the total number of lit cycles with L plus the offset or the gap. Polarity handling is reached by resetting with each pair of sense values and, separately, by changing the sense bits after sampling.

// File: rtl/led_beacon_pkg.sv
package led_beacon_pkg;

  localparam int NUM_LEDS = 2;

  // Selector codes shared by the datapath and the documentation.
  typedef enum logic [3:0] {
    SRC_LINK       = 4'd0,
    SRC_TX         = 4'd1,
    SRC_RX         = 4'd2,
    SRC_COL        = 4'd3,
    SRC_DUPLEX     = 4'd4,
    SRC_TXRX       = 4'd5,
    SRC_LINK_DOWN  = 4'd6,
    SRC_ON         = 4'd8,
    SRC_OFF        = 4'd9,
    SRC_BLINK_FAST = 4'd10,
    SRC_BLINK_SLOW = 4'd11
  } ledSrc_e;

  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic sample;     // latch the polarity this cycle
    logic ready;      // polarity is known
    logic tick;       // millisecond tick
    logic slowPhase;  // slow blink level
    logic fastPhase;  // fast blink level
  } ledStrobes_t;

endpackage

// File: rtl/led_beacon_ctrl.sv
module led_beacon_ctrl
  import led_beacon_pkg::*;
#(
  parameter int SENSE_CYCLES = 8,
  parameter int FAST_HALF    = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        msTick,
  output ledStrobes_t strobes
);

  localparam int SLOW_HALF   = 2 * FAST_HALF;
  localparam int SLOW_PERIOD = 2 * SLOW_HALF;
  localparam int PW          = $clog2(SLOW_PERIOD + 1);
  localparam int SW          = $clog2(SENSE_CYCLES + 1);

  logic [SW-1:0] senseCnt;
  logic          ready;
  logic          sampleNow;
  logic [PW-1:0] blinkCnt;

  assign sampleNow = !ready && (senseCnt == SW'(SENSE_CYCLES - 1));

  // Settle window after reset; the polarity is sampled at its end.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseCnt <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      if (sampleNow) ready <= 1'b1;
      else           senseCnt <= senseCnt + 1'b1;
    end
  end

  // Free-running blink phase counter, advanced by the millisecond tick.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkCnt <= '0;
    end else if (msTick) begin
      if (blinkCnt == PW'(SLOW_PERIOD - 1)) blinkCnt <= '0;
      else                                  blinkCnt <= blinkCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.sample    = sampleNow;
    strobes.ready     = ready;
    strobes.tick      = msTick;
    strobes.slowPhase = (blinkCnt < PW'(SLOW_HALF));
    strobes.fastPhase = (blinkCnt < PW'(FAST_HALF)) ||
                        ((blinkCnt >= PW'(SLOW_HALF)) &&
                         (blinkCnt < PW'(SLOW_HALF + FAST_HALF)));
  end

endmodule

// File: rtl/led_beacon_stretch.sv
module led_beacon_stretch #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tick,
  input  logic          evt,
  input  logic          en,
  input  logic [CW-1:0] len,
  output logic          lit
);

  logic [CW-1:0] holdCnt;

  // An event (re)loads the full length; ticks count it down.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        holdCnt <= '0;
    else if (evt)                     holdCnt <= len;
    else if (tick && holdCnt != '0)   holdCnt <= holdCnt - 1'b1;
  end

  assign lit = evt || (en && (holdCnt != '0));

endmodule

// File: rtl/led_beacon_path.sv
module led_beacon_path
  import led_beacon_pkg::*;
#(
  parameter int NORM_LEN = 40,
  parameter int MED_LEN  = 70,
  parameter int LONG_LEN = 140
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ledStrobes_t              strobes,
  input  logic                     linkUp,
  input  logic                     txActive,
  input  logic                     rxActive,
  input  logic                     collision,
  input  logic                     fullDuplex,
  input  logic [NUM_LEDS-1:0][3:0] cfg,
  input  logic                     stretchEn,
  input  logic [1:0]               stretchSel,
  input  logic [NUM_LEDS-1:0]      sense,
  output logic [NUM_LEDS-1:0]      pinOut,
  output logic [NUM_LEDS-1:0]      pinOe,
  output logic                     duplexDefault
);

  localparam int CW = $clog2(LONG_LEN + 1);

  logic [NUM_LEDS-1:0] polSink;
  logic [CW-1:0]       stretchLen;

  always_comb begin
    case (stretchSel)
      2'd0:    stretchLen = CW'(NORM_LEN);
      2'd1:    stretchLen = CW'(MED_LEN);
      default: stretchLen = CW'(LONG_LEN);
    endcase
  end

  // Wiring polarity, captured once per reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               polSink <= '0;
    else if (strobes.sample) polSink <= sense;
  end

  assign duplexDefault = polSink[NUM_LEDS-1];

  for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
    logic actEvt;
    logic stretched;
    logic litNow;

    always_comb begin
      case (cfg[i])
        SRC_TX:   actEvt = txActive;
        SRC_RX:   actEvt = rxActive;
        SRC_COL:  actEvt = collision;
        SRC_TXRX: actEvt = txActive || rxActive;
        default:  actEvt = 1'b0;
      endcase
    end

    led_beacon_stretch #(.CW(CW)) stretch_i (
      .clk  (clk),
      .rstN (rstN),
      .tick (strobes.tick),
      .evt  (actEvt),
      .en   (stretchEn),
      .len  (stretchLen),
      .lit  (stretched)
    );

    always_comb begin
      case (cfg[i])
        SRC_LINK:                         litNow = linkUp;
        SRC_TX, SRC_RX, SRC_COL, SRC_TXRX: litNow = stretched;
        SRC_DUPLEX:                       litNow = fullDuplex;
        SRC_LINK_DOWN:                    litNow = !linkUp;
        SRC_ON:                           litNow = 1'b1;
        SRC_BLINK_FAST:                   litNow = strobes.fastPhase;
        SRC_BLINK_SLOW:                   litNow = strobes.slowPhase;
        default:                          litNow = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinOut[i] <= 1'b0;
        pinOe[i]  <= 1'b0;
      end else begin
        pinOe[i]  <= strobes.ready;
        pinOut[i] <= strobes.ready && (litNow ^ polSink[i]);
      end
    end
  end

endmodule

// File: rtl/led_beacon_top.sv
module led_beacon_top
  import led_beacon_pkg::*;
#(
  parameter int SENSE_CYCLES = 8,
  parameter int FAST_HALF    = 50,
  parameter int NORM_LEN     = 40,
  parameter int MED_LEN      = 70,
  parameter int LONG_LEN     = 140
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       linkUp,
  input  logic       txActive,
  input  logic       rxActive,
  input  logic       collision,
  input  logic       fullDuplex,
  input  logic [3:0] cfgA,
  input  logic [3:0] cfgB,
  input  logic       stretchEn,
  input  logic [1:0] stretchSel,
  input  logic       senseA,
  input  logic       senseB,
  output logic       ledAOut,
  output logic       ledAOe,
  output logic       ledBOut,
  output logic       ledBOe,
  output logic       duplexDefault
);

  ledStrobes_t               strobes;
  logic [NUM_LEDS-1:0][3:0]  cfgAll;
  logic [NUM_LEDS-1:0]       senseAll;
  logic [NUM_LEDS-1:0]       pinOut;
  logic [NUM_LEDS-1:0]       pinOe;

  assign cfgAll   = {cfgB, cfgA};
  assign senseAll = {senseB, senseA};

  led_beacon_ctrl #(
    .SENSE_CYCLES (SENSE_CYCLES),
    .FAST_HALF    (FAST_HALF)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .msTick  (msTick),
    .strobes (strobes)
  );

  led_beacon_path #(
    .NORM_LEN (NORM_LEN),
    .MED_LEN  (MED_LEN),
    .LONG_LEN (LONG_LEN)
  ) path_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .linkUp        (linkUp),
    .txActive      (txActive),
    .rxActive      (rxActive),
    .collision     (collision),
    .fullDuplex    (fullDuplex),
    .cfg           (cfgAll),
    .stretchEn     (stretchEn),
    .stretchSel    (stretchSel),
    .sense         (senseAll),
    .pinOut        (pinOut),
    .pinOe         (pinOe),
    .duplexDefault (duplexDefault)
  );

  assign ledAOut = pinOut[0];
  assign ledBOut = pinOut[1];
  assign ledAOe  = pinOe[0];
  assign ledBOe  = pinOe[1];

endmodule

// File: rtl/led_beacon_chk.sv
module led_beacon_chk #(
  parameter int SENSE_CYCLES = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] cfgB,
  input logic       ledAOut,
  input logic       ledAOe,
  input logic       ledBOut,
  input logic       ledBOe,
  input logic       duplexDefault
);

  localparam int CYW = $clog2(SENSE_CYCLES + 2);

  // Edges since reset release, saturating just past the settle window.
  logic [CYW-1:0] cyc;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              cyc <= '0;
    else if (cyc != CYW'(SENSE_CYCLES + 1)) cyc <= cyc + 1'b1;
  end

  a_r1_quiet_during_sense: assert property (@(posedge clk) disable iff (!rstN)
    (cyc <= CYW'(SENSE_CYCLES)) |-> (!ledAOe && !ledBOe));

  a_r1_undriven_low: assert property (@(posedge clk) disable iff (!rstN)
    (!ledAOe || !ledBOe) |-> (!ledAOut && !ledBOut && ledAOe == ledBOe));

  a_r4_enable_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ledAOe |=> (ledAOe && ledBOe));

  a_r3_duplex_frozen: assert property (@(posedge clk) disable iff (!rstN)
    ledBOe |=> $stable(duplexDefault));

  a_r5_force_on_b: assert property (@(posedge clk) disable iff (!rstN)
    (ledBOe && $past(ledBOe) && $past(cfgB) == 4'd8) |-> (ledBOut == !duplexDefault));

  a_r5_force_off_b: assert property (@(posedge clk) disable iff (!rstN)
    (ledBOe && $past(ledBOe) && $past(cfgB) == 4'd9) |-> (ledBOut == duplexDefault));

endmodule

bind led_beacon_top led_beacon_chk #(.SENSE_CYCLES(SENSE_CYCLES)) chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .cfgB          (cfgB),
  .ledAOut       (ledAOut),
  .ledAOe        (ledAOe),
  .ledBOut       (ledBOut),
  .ledBOe        (ledBOe),
  .duplexDefault (duplexDefault)
);

// File: tb/led_beacon_tb.sv
`timescale 1ns/1ps
module led_beacon_top_tb_top;

  localparam int S = 8;
  localparam int LEN_N = 40, LEN_M = 70, LEN_L = 140;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b1;
  logic linkUp = 0, txActive = 0, rxActive = 0, collision = 0, fullDuplex = 0;
  logic [3:0] cfgA = 4'd9, cfgB = 4'd9;
  logic stretchEn = 1'b0;
  logic [1:0] stretchSel = 2'd0;
  logic senseA = 0, senseB = 0;
  logic ledAOut, ledAOe, ledBOut, ledBOe, duplexDefault;

  int checks = 0;
  int errors = 0;
  bit polA = 0, polB = 0;   // bench copy of the sense bits used at the last reset

  always #2 clk = ~clk;

  led_beacon_top dut_i (
    .clk(clk), .rstN(rstN), .msTick(msTick), .linkUp(linkUp),
    .txActive(txActive), .rxActive(rxActive), .collision(collision),
    .fullDuplex(fullDuplex), .cfgA(cfgA), .cfgB(cfgB),
    .stretchEn(stretchEn), .stretchSel(stretchSel),
    .senseA(senseA), .senseB(senseB),
    .ledAOut(ledAOut), .ledAOe(ledAOe), .ledBOut(ledBOut), .ledBOe(ledBOe),
    .duplexDefault(duplexDefault)
  );

  task automatic expectEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit rawLit(input int code, input bit lk, input bit tx,
                                input bit rx, input bit col, input bit dup);
    case (code)
      0: return lk;
      1: return tx;
      2: return rx;
      3: return col;
      4: return dup;
      5: return tx | rx;
      6: return !lk;
      8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit pinFor(input bit lit, input bit pol);
    return pol ? !lit : lit;
  endfunction

  task automatic doReset(input bit sA, input bit sB);
    int n;
    @(negedge clk);
    rstN = 1'b0; senseA = sA; senseB = sB; polA = sA; polB = sB;
    repeat (3) @(negedge clk);
    expectEq("R1 oeA in reset", ledAOe, 0);
    expectEq("R1 oeB in reset", ledBOe, 0);
    expectEq("R1 pins low in reset", {ledAOut, ledBOut}, 0);
    expectEq("R1 duplex in reset", duplexDefault, 0);
    rstN = 1'b1;
    n = 0;
    while (!ledAOe && n < 100) begin
      @(negedge clk);
      n++;
      if (!ledAOe) expectEq("R1 pins low while sensing", {ledAOut, ledBOut}, 0);
    end
    expectEq("R1 edges until enable", n, S + 1);
    expectEq("R1 enables together", ledBOe, 1);
    expectEq("R3 duplex default", duplexDefault, sB);
  endtask

  task automatic setEvt(input int src, input bit v);
    case (src)
      0: txActive = v;
      1: rxActive = v;
      default: collision = v;
    endcase
  endtask

  // Pulse an event at cycle 0 (and optionally at cycle second), hold
  // msTick low for cycles 0..gap-1, and count lit samples over 220 cycles.
  task automatic runPulse(input int led, input int src, input int second,
                          input int gap, output int lit);
    repeat (160) @(negedge clk);
    lit = 0;
    setEvt(src, 1'b1);
    if (gap > 0) msTick = 1'b0;
    for (int i = 0; i < 220; i++) begin
      @(negedge clk);
      if (i == 0) setEvt(src, 1'b0);
      if (second > 0 && i == second - 1) setEvt(src, 1'b1);
      if (second > 0 && i == second) setEvt(src, 1'b0);
      if (gap > 0 && i == gap - 1) msTick = 1'b1;
      if (led == 0) lit += (ledAOut ^ polA) ? 1 : 0;
      else          lit += (ledBOut ^ polB) ? 1 : 0;
    end
  endtask

  task automatic blinkRun(input int code, output int lit, output int trans);
    bit prev, cur;
    @(negedge clk);
    cfgA = code[3:0];
    repeat (3) @(negedge clk);
    prev = ledAOut ^ polA;
    lit = 0; trans = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cur = ledAOut ^ polA;
      lit += cur ? 1 : 0;
      if (cur != prev) trans++;
      prev = cur;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int lit, trans;
    int lens[4];
    lens[0] = LEN_N; lens[1] = LEN_M; lens[2] = LEN_L; lens[3] = LEN_L;

    // R1, R2, R3: sources on A, sinks on B
    doReset(1'b0, 1'b1);
    @(negedge clk); cfgA = 4'd8; cfgB = 4'd8;
    @(negedge clk);
    expectEq("R2 A sourcing forced on", ledAOut, 1);
    expectEq("R2 B sinking forced on", ledBOut, 0);
    cfgA = 4'd9; cfgB = 4'd9;
    @(negedge clk);
    expectEq("R2 A sourcing forced off", ledAOut, 0);
    expectEq("R2 B sinking forced off", ledBOut, 1);

    // R4: sense changes after sampling are ignored
    senseA = 1'b1; senseB = 1'b0; cfgA = 4'd8;
    repeat (5) @(negedge clk);
    expectEq("R4 A drive keeps old polarity", ledAOut, 1);
    expectEq("R4 B drive keeps old polarity", ledBOut, 1);
    expectEq("R4 duplex unchanged", duplexDefault, 1);

    // R2, R3: swapped wiring after a fresh reset
    doReset(1'b1, 1'b0);
    @(negedge clk); cfgA = 4'd8; cfgB = 4'd8;
    @(negedge clk);
    expectEq("R2 A sinking forced on", ledAOut, 0);
    expectEq("R2 B sourcing forced on", ledBOut, 1);

    // R5, R8: sweep of all non-blink codes over all level/event inputs, raw
    stretchEn = 1'b0;
    for (int led = 0; led < 2; led++) begin
      for (int code = 0; code < 16; code++) begin
        if (code == 10 || code == 11) continue;
        for (int v = 0; v < 32; v++) begin
          @(negedge clk);
          if (led == 0) cfgA = code[3:0]; else cfgB = code[3:0];
          {linkUp, txActive, rxActive, collision, fullDuplex} = v[4:0];
          @(negedge clk);
          expectEq($sformatf("R5 led%0d code%0d in%0d", led, code, v),
                   led == 0 ? ledAOut : ledBOut,
                   pinFor(rawLit(code, v[4], v[3], v[2], v[1], v[0]),
                          led == 0 ? polA : polB));
        end
      end
    end
    @(negedge clk);
    {linkUp, txActive, rxActive, collision, fullDuplex} = 5'b0;

    // R8: raw event shown for its own cycle only
    cfgA = 4'd1;
    runPulse(0, 0, 0, 0, lit);
    expectEq("R8 raw pulse length", lit, 1);

    // R6: each stretch length
    stretchEn = 1'b1;
    for (int sel = 0; sel < 4; sel++) begin
      stretchSel = sel[1:0];
      runPulse(0, 0, 0, 0, lit);
      expectEq($sformatf("R6 stretch sel%0d", sel), lit, lens[sel] + 1);
    end
    stretchSel = 2'd1; cfgB = 4'd3;
    runPulse(1, 2, 0, 0, lit);
    expectEq("R6 collision on B medium", lit, LEN_M + 1);
    cfgB = 4'd5;
    runPulse(1, 1, 0, 0, lit);
    expectEq("R6 rx via tx-or-rx on B", lit, LEN_M + 1);

    // R7: retrigger restarts full length
    stretchSel = 2'd0;
    runPulse(0, 0, 20, 0, lit);
    expectEq("R7 retrigger at 20", lit, 20 + LEN_N + 1);
    runPulse(0, 0, 39, 0, lit);
    expectEq("R7 retrigger at 39", lit, 39 + LEN_N + 1);

    // R10: count frozen without ticks
    runPulse(0, 0, 0, 30, lit);
    expectEq("R10 tick gap 30", lit, LEN_N + 30);

    // R9: blink duty and rate
    blinkRun(11, lit, trans);
    expectEq("R9 slow blink lit", lit, 100);
    expectEq("R9 slow blink edges", trans, 2);
    blinkRun(10, lit, trans);
    expectEq("R9 fast blink lit", lit, 100);
    expectEq("R9 fast blink edges", trans, 4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule